// File: doc/BRIEF.md
# Perfect Destination Address Filter

This block decides whether a received Ethernet frame is addressed to this station. A table of sixteen 48-bit addresses is loaded from a 192-byte setup frame, which arrives as a byte stream. The first byte of the stream is flagged with a start marker. In every 12-byte entry, each 16-bit half of the address is written twice in a row. Only the first copy is kept, and the second copy is compared against it to catch a corrupted setup frame. To receive broadcast frames, software fills one entry with all-ones. Entries that are not needed are filled with the station's own address.

On the receive side, the first six bytes after a frame start are the destination address. They are compared byte by byte against every entry in parallel. One cycle after the sixth byte, the block raises a one-cycle decision strobe together with an accept flag. A new setup frame can be streamed in while frames are still being filtered. The old table keeps deciding until the last setup byte has been taken.

Top module: `perfect_addr_filter`

## Requirements
- R1: After reset `setup_done`, `setup_err` and `match_valid` are low. Until the first complete setup frame has been taken, every decision has `match_accept` low.
- R2: A setup frame is the byte flagged by `setup_sof` plus the next 191 taken bytes: 16 entries of 12 bytes, entry 0 first. For address bytes a0..a5 (a0 is the first destination byte on the wire), an entry holds a0 a1 a0 a1 a2 a3 a2 a3 a4 a5 a4 a5. The entry stores the first copy of each pair.
- R3: `setup_done` pulses for exactly one cycle, in the cycle after the 192nd setup byte is taken. Destination bytes taken from that same cycle onward are compared against the new table.
- R4: `setup_err` is updated together with `setup_done`. It is high if any second copy in that load differed from its first copy, and low otherwise. It holds that value until the next completed load. The table is committed in either case.
- R5: While a load is in progress, the previous table stays in use. A byte flagged by `setup_sof` during a load restarts the load at entry 0 and discards the partial one, with no `setup_done` pulse.
- R6: Setup bytes with `setup_valid` low are ignored. So are bytes with `setup_sof` low when no load is in progress. Neither kind changes the table, the load position or the outputs.
- R7: The byte taken with `rx_sof` is destination byte 0. The next five taken bytes are bytes 1 to 5. `match_valid` is high for one cycle, in the cycle after byte 5 is taken. `match_accept` is high with it exactly when all six bytes equal one stored entry.
- R8: Cycles with `rx_valid` low are skipped, even if `rx_sof` is high. Bytes after the sixth produce no further decision. A new `rx_sof` restarts the comparison at byte 0.
- R9: The broadcast address is accepted only while some entry holds all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| setup_valid | input | 1 | A setup byte is present |
| setup_sof | input | 1 | The setup byte is the first byte of a setup frame |
| setup_data | input | 8 | Setup byte |
| rx_valid | input | 1 | A received byte is present |
| rx_sof | input | 1 | The received byte is the first destination byte |
| rx_data | input | 8 | Received byte |
| setup_done | output | 1 | One-cycle pulse when a loaded table is committed |
| setup_err | output | 1 | The last committed load had a duplicate-copy mismatch |
| match_valid | output | 1 | One-cycle decision strobe |
| match_accept | output | 1 | The destination matched an entry; valid with match_valid |

## Verification
Several properties are checked on every cycle:
- a decision strobe never lasts two cycles, and accept never appears without it;
- the load position stays inside an entry;
- `setup_err` changes only when a load completes;
- the active table is unchanged in every cycle without a commit;
- nothing is accepted before a table exists.

Other behaviours need the bench's scenarios:
- the byte layout of an entry, and the exact cycle in which a new table starts to decide;
- that a partial load is discarded and the old table keeps working during it;
- that mismatched copies are flagged;
- that single-bit changes in any destination byte of any entry are rejected.

// File: rtl/paf_pkg.sv
package paf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int BYTE_W     = 8;
endpackage

// File: rtl/paf_setup_parse.sv
module paf_setup_parse
    import paf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_valid,
    input  logic s_sof,
    input  logic [BYTE_W-1:0] s_data,
    output logic [ENTRIES-1:0][ADDR_BYTES-1:0][BYTE_W-1:0] shadow,
    output logic commit,
    output logic done,
    output logic err
);
    localparam int ENTRY_BYTES = 2 * ADDR_BYTES;
    localparam int POS_W       = $clog2(ENTRY_BYTES);
    localparam int ENT_W       = $clog2(ENTRIES);
    localparam int BI_W        = $clog2(ADDR_BYTES);

    typedef struct packed {
        logic                 loading;
        logic [POS_W-1:0]     pos;
        logic [ENT_W-1:0]     ent;
        logic                 bad;
        logic                 done;
        logic                 err;
        logic [ENTRIES-1:0][ADDR_BYTES-1:0][BYTE_W-1:0] shadow;
    } parse_t;

    parse_t p_q, p_d;
    logic [POS_W-1:0] pos_c;
    logic [ENT_W-1:0] ent_c;
    logic [BI_W-1:0]  bidx_c;
    logic take_c, bad_c, mism_c;

    // byte index inside the address: halfword group (pos/4) times two, plus odd/even
    assign pos_c  = s_sof ? '0 : p_q.pos;
    assign ent_c  = s_sof ? '0 : p_q.ent;
    assign bad_c  = s_sof ? 1'b0 : p_q.bad;
    assign take_c = s_valid && (s_sof || p_q.loading);
    assign bidx_c = BI_W'({pos_c >> 2, 1'b0}) | BI_W'(pos_c[0]);

    always_comb begin
        p_d    = p_q;
        p_d.done = 1'b0;
        commit = 1'b0;
        mism_c = 1'b0;
        if (take_c) begin
            if (!pos_c[1]) begin
                p_d.shadow[ent_c][bidx_c] = s_data;
            end else begin
                mism_c = (p_q.shadow[ent_c][bidx_c] != s_data);
            end
            p_d.bad     = bad_c | mism_c;
            p_d.loading = 1'b1;
            if (pos_c == POS_W'(ENTRY_BYTES - 1)) begin
                p_d.pos = '0;
                if (ent_c == ENT_W'(ENTRIES - 1)) begin
                    commit      = 1'b1;
                    p_d.loading = 1'b0;
                    p_d.ent     = '0;
                    p_d.done    = 1'b1;
                    p_d.err     = bad_c | mism_c;
                end else begin
                    p_d.ent = ent_c + 1'b1;
                end
            end else begin
                p_d.pos = pos_c + 1'b1;
                p_d.ent = ent_c;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign shadow = p_q.shadow;
    assign done   = p_q.done;
    assign err    = p_q.err;

    // R2: load position never leaves an entry
    a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.pos < POS_W'(ENTRY_BYTES));
    // R3: a commit needs a whole frame, so the pulse cannot repeat next cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: the error flag moves only together with a completed load
    a_r4_err_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(err));
endmodule

// File: rtl/paf_match.sv
module paf_match
    import paf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_sof,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic [ENTRIES-1:0][ADDR_BYTES-1:0][BYTE_W-1:0] table_in,
    input  logic table_ok,
    output logic dec_valid,
    output logic dec_accept
);
    localparam int IDX_W = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic [ENTRIES-1:0] hit;
        logic               valid;
        logic               accept;
    } match_t;

    match_t m_q, m_d;
    logic [IDX_W-1:0]   cur_c;
    logic [ENTRIES-1:0] eq_c;
    logic               in_addr_c;

    assign cur_c     = rx_sof ? '0 : m_q.idx;
    assign in_addr_c = (cur_c < IDX_W'(ADDR_BYTES));

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign eq_c[gi] = in_addr_c && (table_in[gi][cur_c] == rx_data);
    end

    always_comb begin
        m_d        = m_q;
        m_d.valid  = 1'b0;
        m_d.accept = 1'b0;
        if (rx_valid && in_addr_c) begin
            m_d.hit = eq_c & ((cur_c == '0) ? {ENTRIES{1'b1}} : m_q.hit);
            m_d.idx = cur_c + 1'b1;
            if (cur_c == IDX_W'(ADDR_BYTES - 1)) begin
                m_d.valid  = 1'b1;
                m_d.accept = table_ok & (|m_d.hit);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q     <= '0;
            m_q.idx <= IDX_W'(ADDR_BYTES);
        end else begin
            m_q <= m_d;
        end
    end

    assign dec_valid  = m_q.valid;
    assign dec_accept = m_q.accept;

    // R7: six bytes lie between decisions, so the strobe never lasts two cycles
    a_r7_single_decision: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    // R7: accept only appears with the strobe
    a_r7_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);
endmodule

// File: rtl/perfect_addr_filter.sv
module perfect_addr_filter
    import paf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic setup_valid,
    input  logic setup_sof,
    input  logic [7:0] setup_data,
    input  logic rx_valid,
    input  logic rx_sof,
    input  logic [7:0] rx_data,
    output logic setup_done,
    output logic setup_err,
    output logic match_valid,
    output logic match_accept
);
    typedef struct packed {
        logic loaded;
        logic [ENTRIES-1:0][ADDR_BYTES-1:0][BYTE_W-1:0] act;
    } tbl_t;

    tbl_t t_q, t_d;
    logic [ENTRIES-1:0][ADDR_BYTES-1:0][BYTE_W-1:0] shadow_w;
    logic commit_w;

    paf_setup_parse #(.ENTRIES(ENTRIES)) i_parse (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (setup_valid),
        .s_sof   (setup_sof),
        .s_data  (setup_data),
        .shadow  (shadow_w),
        .commit  (commit_w),
        .done    (setup_done),
        .err     (setup_err)
    );

    // active table: replaced as a whole only when a load completes
    always_comb begin
        t_d = t_q;
        if (commit_w) begin
            t_d.act    = shadow_w;
            t_d.loaded = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    paf_match #(.ENTRIES(ENTRIES)) i_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_data    (rx_data),
        .table_in   (t_q.act),
        .table_ok   (t_q.loaded),
        .dec_valid  (match_valid),
        .dec_accept (match_accept)
    );

    // R5: the table in use changes only at a commit
    a_r5_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_w |=> $stable(t_q.act));
    // R1: nothing is accepted before a table exists
    a_r1_reject_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
        !t_q.loaded |-> !match_accept);
endmodule

// File: tb/test_perfect_addr_filter.sv
`timescale 1ps/1ps
module test_perfect_addr_filter;
    localparam int N    = 16;
    localparam int HALF = 2500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_valid = 1'b0, setup_sof = 1'b0, rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0] setup_data = 8'h00, rx_data = 8'h00;
    logic setup_done, setup_err, match_valid, match_accept;

    always #HALF clk = ~clk;

    perfect_addr_filter #(.ENTRIES(N)) i_perfect_addr_filter (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_sof(setup_sof), .setup_data(setup_data),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .setup_done(setup_done), .setup_err(setup_err),
        .match_valid(match_valid), .match_accept(match_accept)
    );

    int checks = 0, errors = 0, vpulses = 0, dpulses = 0;
    logic last_acc = 1'b0;
    longint done_t = 0;
    logic [47:0] exp_tbl [N];
    logic [47:0] nt [N];
    logic loaded = 1'b0;

    always @(negedge clk) begin
        if (match_valid) begin vpulses++; last_acc = match_accept; end
        if (setup_done) begin dpulses++; done_t = $time; end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drv(bit sv, bit ss, logic [7:0] sd, bit rv, bit rs, logic [7:0] rd);
        @(negedge clk);
        setup_valid = sv; setup_sof = ss; setup_data = sd;
        rx_valid = rv; rx_sof = rs; rx_data = rd;
    endtask

    task automatic idle();
        drv(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    endtask

    function automatic logic expect_acc(logic [47:0] a);
        logic r;
        r = 1'b0;
        for (int k = 0; k < N; k++) if (exp_tbl[k] == a) r = 1'b1;
        return r & loaded;
    endfunction

    function automatic logic [47:0] mk(int seed, int k);
        return {8'(seed + 7 * k), 8'(k ^ 8'h5C), 8'(seed * 3 + 1), 8'(k), 8'(seed), 8'h02};
    endfunction

    // setup stream: entry layout a0 a1 a0 a1 a2 a3 a2 a3 a4 a5 a4 a5 (R2)
    task automatic load(bit corrupt, int cut, output longint last_t);
        int n;
        logic [7:0] b;
        n = 0;
        last_t = 0;
        for (int k = 0; k < N; k++) begin
            for (int p = 0; p < 12; p++) begin
                if (n == cut) return;
                b = nt[k][8 * (2 * (p / 4) + (p % 2)) +: 8];
                if (corrupt && k == 3 && p == 6) b = b ^ 8'h10;
                drv(1'b1, n == 0, b, 1'b0, 1'b0, 8'h00);
                last_t = $time;
                n++;
                // R6: valid-low gap with garbage and a stray start marker
                if (n % 7 == 0 && n < N * 12) drv(1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, 8'h00);
            end
        end
    endtask

    task automatic commit_expect();
        for (int k = 0; k < N; k++) exp_tbl[k] = nt[k];
        loaded = 1'b1;
    endtask

    task automatic after_load(bit corrupt, longint last_t, int d0);
        idle(); idle();
        chk("R3", "setup_done pulse count", dpulses - d0, 1);
        chk("R3", "setup_done cycle offset", done_t - last_t, 2 * HALF);
        chk("R3", "setup_done one cycle", setup_done, 0);
        chk("R4", "setup_err", setup_err, corrupt);
    endtask

    task automatic frame(logic [47:0] a, int extra, bit gap, bit restart, string req);
        int v0;
        logic e;
        e = expect_acc(a);
        v0 = vpulses;
        if (restart) begin
            drv(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h77);
            drv(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h66);
            drv(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h55);
        end
        for (int i = 0; i < 6 + extra; i++) begin
            drv(1'b0, 1'b0, 8'h00, 1'b1, i == 0, (i < 6) ? a[8 * i +: 8] : 8'hE1);
            if (gap && i == 2) drv(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h99);
        end
        idle(); idle();
        chk(req, "decision count", vpulses - v0, 1);
        chk(req, "accept", last_acc, e);
    endtask

    initial begin
        #(64'd750000000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint lt;
        int d0;
        for (int k = 0; k < N; k++) exp_tbl[k] = 48'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "setup_done after reset", setup_done, 0);
        chk("R1", "setup_err after reset", setup_err, 0);
        chk("R1", "match_valid after reset", match_valid, 0);
        rst_n = 1'b1;
        idle();
        frame(48'h0, 0, 1'b0, 1'b0, "R1");
        frame(48'hFFFF_FFFF_FFFF, 0, 1'b0, 1'b0, "R1");

        // table A with broadcast in the last entry
        for (int k = 0; k < N; k++) nt[k] = mk(1, k);
        nt[N - 1] = 48'hFFFF_FFFF_FFFF;
        d0 = dpulses;
        load(1'b0, -1, lt);
        commit_expect();
        after_load(1'b0, lt, d0);
        for (int k = 0; k < N; k++) frame(exp_tbl[k], 0, 1'b0, 1'b0, "R2");
        for (int k = 0; k < N; k++)
            for (int b = 0; b < 6; b++)
                frame(exp_tbl[k] ^ (48'h1 << (8 * b + (k % 8))), 0, 1'b0, 1'b0, "R7");
        frame(48'hFFFF_FFFF_FFFF, 0, 1'b0, 1'b0, "R9");
        frame(exp_tbl[2], 5, 1'b1, 1'b0, "R8");
        frame(exp_tbl[6], 0, 1'b0, 1'b1, "R8");
        frame(exp_tbl[6] ^ 48'h0100_0000_0000, 4, 1'b1, 1'b1, "R8");

        // R6: stray setup bytes outside a load
        d0 = dpulses;
        for (int i = 0; i < 200; i++) drv(1'b1, 1'b0, 8'(i * 3), 1'b0, 1'b0, 8'h00);
        idle(); idle();
        chk("R6", "no commit from stray bytes", dpulses - d0, 0);
        frame(exp_tbl[9], 0, 1'b0, 1'b0, "R6");
        frame(exp_tbl[0], 0, 1'b0, 1'b0, "R6");

        // table B: last entry holds the station address, no broadcast
        for (int k = 0; k < N; k++) nt[k] = mk(9, k);
        nt[N - 1] = nt[0];
        d0 = dpulses;
        load(1'b0, 100, lt);
        idle();
        frame(nt[5], 0, 1'b0, 1'b0, "R5");
        frame(exp_tbl[5], 0, 1'b0, 1'b0, "R5");
        chk("R5", "partial load commits nothing", dpulses - d0, 0);
        d0 = dpulses;
        load(1'b0, -1, lt);
        commit_expect();
        frame(nt[4], 0, 1'b0, 1'b0, "R3");
        chk("R3", "setup_done pulse count", dpulses - d0, 1);
        chk("R3", "setup_done cycle offset", done_t - lt, 2 * HALF);
        chk("R4", "setup_err clean load", setup_err, 0);
        frame(48'hFFFF_FFFF_FFFF, 0, 1'b0, 1'b0, "R9");
        frame(mk(1, 3), 0, 1'b0, 1'b0, "R5");
        for (int k = 0; k < N; k++) frame(exp_tbl[k], 0, 1'b0, 1'b0, "R2");

        // table C: corrupted copy, then a clean reload
        for (int k = 0; k < N; k++) nt[k] = mk(20, k);
        d0 = dpulses;
        load(1'b1, -1, lt);
        commit_expect();
        after_load(1'b1, lt, d0);
        frame(exp_tbl[7], 0, 1'b0, 1'b0, "R4");
        idle(); idle();
        chk("R4", "setup_err held", setup_err, 1);
        d0 = dpulses;
        load(1'b0, -1, lt);
        commit_expect();
        after_load(1'b0, lt, d0);
        frame(exp_tbl[3], 0, 1'b0, 1'b0, "R4");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule